// File: doc/BRIEF.md
# Multi-Tile Pulse Duration Accumulator

This block turns pulse-width readouts from a set of analog sub-tiles into short signed digital codes. Each sub-tile drives one pulse line per output lane. A pulse carries a magnitude as the number of clock cycles it stays high. A per-line sign bit says whether that magnitude is added or subtracted. A measurement window strobe brackets each pulse measurement. A 4-bit saturating counter on every line counts the cycles in which both the window and the pulse are high.

When the window closes, each lane's signed counts from all sub-tiles are reduced by a pipelined binary adder tree. Every level of the tree takes one clock cycle. The lane sum is then scaled by a fixed arithmetic shift and clamped to a 5-bit two's-complement code, which gives 32 levels from -16 to +15. One valid pulse marks the moment all lane codes are updated together. The codes stay unchanged until the next valid pulse.

With the default parameters there are 16 sub-tiles and 64 lanes. Pulse line `t*64 + l` belongs to sub-tile `t` and lane `l`. Lane `l`'s code sits in `code_out[l*5 +: 5]`.

Top module: `pulse_sum_quant`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `code_vld` is 0 and every lane code is 0. A reset applied while a result is still in the pipeline cancels that result, so no valid pulse follows for it.
- R2: A line's counter is cleared at the first rising edge at which `meas_win` is seen high after being low. The counter then counts the rising edges at which `meas_win` and the line's pulse are both high. Pulse activity while `meas_win` is low has no effect on the result.
- R3: A line's count saturates at 15 within one window and never wraps, however long the pulse stays high.
- R4: When `neg_in` for a line is 1 at the closing edge, that line's count is subtracted from its lane sum. When it is 0, the count is added.
- R5: Each lane sum is the signed total of the counts of the 16 lines `t*64 + l` of that lane, one line from each sub-tile.
- R6: The lane code is floor(sum / 8), which is an arithmetic right shift by 3. It is clamped to the range -16 to +15 and given as 5-bit two's complement.
- R7: `code_vld` is high for exactly one cycle. It rises at the 5th rising edge, counting as the 1st the edge at which `meas_win` is first seen low after being high. That is one cycle for count capture plus four adder levels. All lane codes change at that same edge.
- R8: Between valid pulses, every lane code holds its value.
- R9: A new window starts from zero counts, so nothing from a previous window carries into its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one count unit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| meas_win | input | 1 | Measurement window strobe; high while pulses are measured |
| pulse_in | input | 1024 | Pulse lines; bit `t*64+l` is sub-tile t, lane l |
| neg_in | input | 1024 | Per-line sign; 1 subtracts that line's count |
| code_out | output | 320 | Lane codes, 5-bit two's complement; lane l at `[l*5 +: 5]` |
| code_vld | output | 1 | One-cycle strobe marking new lane codes |

## Verification
Hashed per-line pulse lengths and signs are run with window lengths of 1, 4, 10 and 20 cycles. A short window tells apart counting that is gated by the window from counting of raw pulse length. Longer windows with pulses of 16 to 18 cycles expose any counter that wraps instead of saturating. Mixed signs across sub-tiles separate subtraction from addition, and they show whether the lane-to-line mapping is correct. Uniform all-positive and all-negative full-scale patterns drive the code to both clamps, where floor rounding and wrap-around would give different codes. Pulses held high before a window, back-to-back windows and a reset in mid-pipeline show that stale counts and cancelled results never reach the outputs.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int DEF_TILES  = 16;
    localparam int DEF_LANES  = 64;
    localparam int DEF_CNT_W  = 4;
    localparam int DEF_SHIFT  = 3;
    localparam int CODE_W     = 5;
    localparam int CODE_MAX   = (1 << (CODE_W - 1)) - 1;
    localparam int CODE_MIN   = -(1 << (CODE_W - 1));

    typedef logic signed [CODE_W-1:0] code_t;

    typedef struct packed {
        logic start;   // window opens this edge
        logic run;     // window is high this edge
        logic close;   // window seen low after being high
    } win_ev_t;

    function automatic code_t to_code(int sum, int sh);
        int q;
        q = sum >>> sh;
        if (q > CODE_MAX) q = CODE_MAX;
        if (q < CODE_MIN) q = CODE_MIN;
        return code_t'(q);
    endfunction

endpackage

// File: rtl/window_ctl.sv
module window_ctl
    import psq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    meas_win,
    output win_ev_t ev,
    output logic    load,
    output logic    valid
);

    logic             win_q;
    logic [DEPTH:0]   vpipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            vpipe <= '0;
        end else begin
            win_q <= meas_win;
            vpipe <= {vpipe[DEPTH-1:0], ev.close};
        end
    end

    always_comb begin
        ev.start = meas_win & ~win_q;
        ev.run   = meas_win;
        ev.close = ~meas_win & win_q;
    end

    assign load  = vpipe[DEPTH-1];
    assign valid = vpipe[DEPTH];

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

endmodule

// File: rtl/tile_counters.sv
module tile_counters
    import psq_pkg::*;
#(
    parameter int NLINE = 1024,
    parameter int CNT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  win_ev_t                      ev,
    input  logic [NLINE-1:0]             pulse,
    input  logic [NLINE-1:0]             neg,
    output logic [NLINE*(CNT_W+1)-1:0]   contrib
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        logic [CNT_W-1:0] cnt;
        logic [CNT_W:0]   mag;
        logic [CNT_W:0]   held;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
            end else if (ev.start) begin
                cnt <= pulse[i] ? CNT_ONE : '0;
            end else if (ev.run && pulse[i] && (cnt != CNT_MAX)) begin
                cnt <= cnt + CNT_ONE;
            end
        end

        assign mag = {1'b0, cnt};

        always_ff @(posedge clk) begin
            if (rst) begin
                held <= '0;
            end else if (ev.close) begin
                held <= neg[i] ? -mag : mag;
            end
        end

        assign contrib[i*(CNT_W+1) +: (CNT_W+1)] = held;

        // R2
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            ev.start |=> (cnt <= CNT_ONE));

        // R3
        cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
            (ev.run && !ev.start && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
    end

endmodule

// File: rtl/lane_tree.sv
module lane_tree
    import psq_pkg::*;
#(
    parameter int TILES = 16,
    parameter int CNT_W = 4,
    parameter int SHIFT = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [TILES*(CNT_W+1)-1:0]  leaf,
    input  logic                        load,
    output code_t                       code
);

    localparam int SUM_W = CNT_W + 1 + $clog2(TILES);

    logic signed [CNT_W:0]   lraw  [TILES];
    logic signed [SUM_W-1:0] leafv [TILES];
    logic signed [SUM_W-1:0] inner [2:TILES-1];
    logic signed [SUM_W-1:0] root;

    for (genvar t = 0; t < TILES; t++) begin : g_leaf
        assign lraw[t]  = leaf[t*(CNT_W+1) +: (CNT_W+1)];
        assign leafv[t] = SUM_W'(lraw[t]);
    end

    // heap-ordered tree: node i sums nodes 2i and 2i+1, one register per level
    for (genvar i = 2; i < TILES; i++) begin : g_node
        logic signed [SUM_W-1:0] a;
        logic signed [SUM_W-1:0] b;
        if (2 * i >= TILES) begin : g_from_leaf
            assign a = leafv[2*i - TILES];
            assign b = leafv[2*i + 1 - TILES];
        end else begin : g_from_inner
            assign a = inner[2*i];
            assign b = inner[2*i + 1];
        end
        always_ff @(posedge clk) begin
            if (rst) inner[i] <= '0;
            else     inner[i] <= a + b;
        end
    end

    assign root = inner[2] + inner[3];

    always_ff @(posedge clk) begin
        if (rst)       code <= '0;
        else if (load) code <= to_code(int'(root), SHIFT);
    end

endmodule

// File: rtl/pulse_sum_quant.sv
module pulse_sum_quant
    import psq_pkg::*;
#(
    parameter int TILES = DEF_TILES,
    parameter int LANES = DEF_LANES,
    parameter int CNT_W = DEF_CNT_W,
    parameter int SHIFT = DEF_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      meas_win,
    input  logic [TILES*LANES-1:0]    pulse_in,
    input  logic [TILES*LANES-1:0]    neg_in,
    output logic [LANES*CODE_W-1:0]   code_out,
    output logic                      code_vld
);

    localparam int NLINE = TILES * LANES;
    localparam int LW    = CNT_W + 1;
    localparam int LVL   = $clog2(TILES);

    win_ev_t                 ev;
    logic                    load;
    logic [NLINE*LW-1:0]     contrib;

    window_ctl #(.DEPTH(LVL)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .meas_win (meas_win),
        .ev       (ev),
        .load     (load),
        .valid    (code_vld)
    );

    tile_counters #(.NLINE(NLINE), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .pulse   (pulse_in),
        .neg     (neg_in),
        .contrib (contrib)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TILES*LW-1:0] leaf;
        code_t               code;
        for (genvar t = 0; t < TILES; t++) begin : g_pick
            assign leaf[t*LW +: LW] = contrib[(t*LANES + l)*LW +: LW];
        end
        lane_tree #(.TILES(TILES), .CNT_W(CNT_W), .SHIFT(SHIFT)) u_tree (
            .clk  (clk),
            .rst  (rst),
            .leaf (leaf),
            .load (load),
            .code (code)
        );
        assign code_out[l*CODE_W +: CODE_W] = code;
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!code_vld && !$past(rst)) |-> $stable(code_out));

endmodule

// File: tb/sim_pulse_sum_quant.sv
module sim_pulse_sum_quant;

    localparam int NT = 16;
    localparam int NL = 64;
    localparam int CW = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               meas_win = 1'b0;
    logic [NT*NL-1:0]   pulse_in = '0;
    logic [NT*NL-1:0]   neg_in = '0;
    logic [NL*CW-1:0]   code_out;
    logic               code_vld;

    int n_arr [NT][NL];
    bit s_arr [NT][NL];
    int checks = 0;
    int fails  = 0;
    logic [NL*CW-1:0] snap;

    // seed, window length, mode (0 hashed, 1 full positive, 2 full negative)
    localparam int VEC [6][3] = '{
        '{1, 10, 0}, '{2, 20, 0}, '{3, 4, 0},
        '{4, 16, 1}, '{5, 16, 2}, '{6, 1, 0}
    };

    always #10 clk = ~clk;

    pulse_sum_quant u0 (
        .clk(clk), .rst(rst), .meas_win(meas_win),
        .pulse_in(pulse_in), .neg_in(neg_in),
        .code_out(code_out), .code_vld(code_vld)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane_code(int l);
        return int'($signed(code_out[l*CW +: CW]));
    endfunction

    function automatic int exp_code(int l, int wlen);
        int sum = 0;
        for (int t = 0; t < NT; t++) begin
            int c = n_arr[t][l];
            if (c > wlen) c = wlen;
            if (c > 15) c = 15;
            sum += s_arr[t][l] ? -c : c;
        end
        sum = sum >>> 3;
        if (sum > 15) sum = 15;
        if (sum < -16) sum = -16;
        return sum;
    endfunction

    task automatic setup(int seed, int mode);
        for (int t = 0; t < NT; t++) begin
            for (int l = 0; l < NL; l++) begin
                case (mode)
                    1: begin n_arr[t][l] = 20; s_arr[t][l] = 1'b0; end
                    2: begin n_arr[t][l] = 20; s_arr[t][l] = 1'b1; end
                    3: begin n_arr[t][l] = 0;  s_arr[t][l] = 1'b0; end
                    default: begin
                        n_arr[t][l] = (seed*7 + t*3 + l*5 + (l >> 2)) % 19;
                        s_arr[t][l] = 1'(((seed + t + 3*l) >> 1) & 1);
                    end
                endcase
                neg_in[t*NL + l] = s_arr[t][l];
            end
        end
    endtask

    // noise before the window, then wlen edges with the window high
    task automatic drive_window(int wlen);
        @(negedge clk);
        pulse_in = '1;
        meas_win = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < wlen; k++) begin
            meas_win = 1'b1;
            for (int t = 0; t < NT; t++)
                for (int l = 0; l < NL; l++)
                    pulse_in[t*NL + l] = (k < n_arr[t][l]);
            @(negedge clk);
        end
        meas_win = 1'b0;
        pulse_in = '1;
    endtask

    // first posedge after this call is the closing edge
    task automatic close_and_check(int wlen, string req);
        int seen = 0;
        int bad = 0;
        int bl = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (code_vld && seen == 0) seen = c;
            if (c == 5) begin
                for (int l = 0; l < NL; l++) begin
                    if (lane_code(l) != exp_code(l, wlen)) begin
                        if (bad == 0) bl = l;
                        bad++;
                    end
                end
                chk(bad == 0, req, lane_code(bl), exp_code(bl, wlen));
                snap = code_out;
            end
            if (c == 6) chk(!code_vld, "R7 single-cycle valid", int'(code_vld), 0);
            if (c == 8) chk(code_out == snap, "R8 codes hold", int'(code_out[4:0]), int'(snap[4:0]));
        end
        chk(seen == 5, "R7 valid latency", seen, 5);
        pulse_in = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(code_vld == 1'b0, "R1 valid in reset", int'(code_vld), 0);
        chk(code_out == '0, "R1 codes in reset", lane_code(0), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(code_vld == 1'b0 && code_out == '0, "R1 after reset", int'(code_vld), 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            setup(VEC[v][0], VEC[v][2]);
            drive_window(VEC[v][1]);
            close_and_check(VEC[v][1], "R5 R4 R6 lane codes");
        end

        // R3 R6: full positive clamp, saturated counters
        setup(0, 1);
        drive_window(30);
        close_and_check(30, "R3 R6 positive clamp");
        chk(lane_code(7) == 15, "R6 top code", lane_code(7), 15);

        // R6 negative clamp
        setup(0, 2);
        drive_window(18);
        close_and_check(18, "R6 negative clamp");
        chk(lane_code(63) == -16, "R6 bottom code", lane_code(63), -16);

        // R2 R9: window with no pulses after heavy noise and a full window
        setup(0, 3);
        drive_window(5);
        close_and_check(5, "R2 R9 stale counts excluded");
        chk(lane_code(0) == 0, "R9 zero result", lane_code(0), 0);

        // R1: reset in mid-pipeline cancels the result
        begin
            int got = 0;
            setup(0, 1);
            drive_window(8);
            @(negedge clk);
            @(negedge clk);
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
            pulse_in = '0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (code_vld) got = 1;
            end
            chk(got == 0, "R1 no valid after reset", got, 0);
            chk(code_out == '0, "R1 codes cleared", lane_code(0), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule